// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block chooses which interrupt source a 16550-style serial port reports. It takes the interrupt enable bits, the receive error and data-ready status, the receive FIFO fill level and its trigger setting, a character-timeout pending flag, and the modem-status change bits. It also keeps the transmit-empty pending flag itself. From these it forms the 8-bit interrupt identification value and one interrupt request line. Both are registered.

Software reads the identification value through the host bus. The bus decoder gives the block a single read strobe for that register. A read that sees the transmit-empty code acknowledges that source. Writes to the enable register and the holding register reach the block as strobes, and the transmitter reports through a strobe when its holding register has drained.

Top module: `uart_irq_ident`

## Requirements
- R1: While the synchronous active-low reset is held, the block clears the transmit-empty pending flag. After the first clock edge under reset, `iir` reads 0x01 and `irq` is low.
- R2: The sources are ranked in a fixed order, highest first: line status (ID 0x6), character timeout (ID 0xC), received data (ID 0x4), transmit empty (ID 0x2), modem status (ID 0x0). `iir[3:0]` shows the ID of the highest active source. When no source is active, `iir[3:0]` reads 0x1.
- R3: The line status source is active when `ier_bits[2]` is set and at least one bit of `rx_err` (break, framing, parity, overrun) is set.
- R4: The character timeout source is active when `timeout_pend` is set and `ier_bits[0]` is set. It has no enable of its own.
- R5: The received data source needs `ier_bits[0]` and `rx_ready`. With `fifo_on` low, nothing else is needed. With `fifo_on` high, `rx_count` must also be at or above the trigger count chosen by `trig_sel`: 00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14.
- R6: The transmit-empty source is active when `ier_bits[1]` and the internal pending flag are both set. The flag is set by `ier_wr` while `thr_empty` is high, or by `tx_drained`. `thr_wr` clears the flag and wins over any set event in the same cycle.
- R7: An `iir_rd` while `iir[3:0]` shows 0x2 clears the pending flag. A set event in the same cycle wins over this clear.
- R8: The modem status source is active when `ier_bits[3]` is set and at least one bit of `msr_delta` is set.
- R9: `iir[7:6]` reads 11 when `fifo_on` is high and 00 when it is low. `iir[5:4]` always reads 00.
- R10: `irq` is high exactly when `iir[3:0]` is not 0x1. Both outputs reflect the inputs sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ier_bits | input | 4 | Enables: [0] received data and timeout, [1] transmit empty, [2] line status, [3] modem status |
| rx_err | input | 4 | Receive error status: break, framing, parity, overrun |
| rx_ready | input | 1 | Receive data ready |
| fifo_on | input | 1 | FIFO mode enabled |
| rx_count | input | CNT_W | Receive FIFO fill level |
| trig_sel | input | 2 | Receive trigger selection |
| timeout_pend | input | 1 | Character timeout pending |
| thr_empty | input | 1 | Holding register empty status |
| ier_wr | input | 1 | Enable register write strobe |
| thr_wr | input | 1 | Holding register write strobe |
| tx_drained | input | 1 | Transmitter emptied the holding register |
| iir_rd | input | 1 | Identification register read strobe |
| msr_delta | input | 4 | Modem status change bits |
| iir | output | 8 | Interrupt identification value |
| irq | output | 1 | Interrupt request |

## Verification
A level input that changes before clock edge k shows up in `iir` and `irq` right after edge k. A strobe that changes the pending flag at edge k shows up in the outputs only after edge k+1, because the flag is registered in between. The bench drives its inputs on the falling edge and checks the outputs on the next falling edge against the value it predicted for the rising edge in between. It also carries its own copy of the pending flag forward one edge, so each strobe's effect is checked in the cycle the second register delivers it.

// File: rtl/uart_irq_pkg.sv
// Package: shared constants and helpers for the interrupt identification
// logic. Assumes the receive FIFO depth fits the trigger counts used below.
package uart_irq_pkg;

    // Identification codes placed in the low nibble of the IIR.
    localparam logic [3:0] ID_NONE    = 4'h1;
    localparam logic [3:0] ID_LINE    = 4'h6;
    localparam logic [3:0] ID_TIMEOUT = 4'hC;
    localparam logic [3:0] ID_RXDATA  = 4'h4;
    localparam logic [3:0] ID_THRE    = 4'h2;
    localparam logic [3:0] ID_MODEM   = 4'h0;

    localparam int NUM_SRC = 5;

    // Source index, highest priority at index 0.
    typedef enum logic [2:0] {
        SRC_LINE    = 3'd0,
        SRC_TIMEOUT = 3'd1,
        SRC_RXDATA  = 3'd2,
        SRC_THRE    = 3'd3,
        SRC_MODEM   = 3'd4
    } src_e;

    // Code for each source index.
    function automatic logic [3:0] src_code(input int idx);
        case (idx)
            0:       return ID_LINE;
            1:       return ID_TIMEOUT;
            2:       return ID_RXDATA;
            3:       return ID_THRE;
            default: return ID_MODEM;
        endcase
    endfunction

    // Receive trigger count chosen by the two-bit selection.
    function automatic int unsigned trig_count(input logic [1:0] sel);
        case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_thr_flag.sv
// Transmit-empty pending flag.
// Set by an enable-register write while the holding register is empty, or by
// the transmitter draining it. Cleared by a holding-register write (highest
// precedence) or by an IIR read that presented the transmit-empty code.
// Assumes all strobes are single-cycle and synchronous to clk.
module uart_irq_thr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ier_wr,
    input  logic thr_empty,
    input  logic tx_drained,
    input  logic thr_wr,
    input  logic rd_ack,
    output logic pend
);

    logic set_ev;

    // Purpose: collect the events that arm the flag.
    always_comb begin
        set_ev = (ier_wr && thr_empty) || tx_drained;
    end

    // Purpose: hold the flag; write clears first, then set, then read-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (thr_wr) begin
            pend <= 1'b0;
        end else if (set_ev) begin
            pend <= 1'b1;
        end else if (rd_ack) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_rx_gate.sv
// Received-data qualification.
// In FIFO mode, data counts as available only once the fill level reaches the
// selected trigger count. In byte mode, data-ready alone is enough.
// Assumes rx_count never exceeds FIFO_DEPTH.
module uart_irq_rx_gate #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    output logic             rx_avail
);
    import uart_irq_pkg::*;

    logic at_trig;

    // Purpose: compare the fill level against the chosen trigger count.
    always_comb begin
        at_trig = 32'(rx_count) >= trig_count(trig_sel);
    end

    // Purpose: choose the qualification for the active mode.
    always_comb begin
        rx_avail = rx_ready && (!fifo_on || at_trig);
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder: returns the code of the lowest-indexed active
// source, or the "none" code. Assumes index 0 is the highest priority.
module uart_irq_prio #(
    parameter int N = uart_irq_pkg::NUM_SRC
) (
    input  logic [N-1:0] active,
    output logic [3:0]   id
);
    import uart_irq_pkg::*;

    // Purpose: scan from lowest to highest priority so the highest wins.
    always_comb begin
        id = ID_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) id = src_code(i);
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Interrupt identification for a 16550-style serial port.
// Builds the five source requests, ranks them, and registers the resulting
// IIR value and the interrupt line. Assumes all inputs are synchronous to clk.
module uart_irq_ident #(
    parameter int FIFO_DEPTH = 16,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ier_bits,
    input  logic [3:0]       rx_err,
    input  logic             rx_ready,
    input  logic             fifo_on,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             timeout_pend,
    input  logic             thr_empty,
    input  logic             ier_wr,
    input  logic             thr_wr,
    input  logic             tx_drained,
    input  logic             iir_rd,
    input  logic [3:0]       msr_delta,
    output logic [7:0]       iir,
    output logic             irq
);
    import uart_irq_pkg::*;

    logic               thr_pend;
    logic               rd_ack;
    logic               rx_avail;
    logic [NUM_SRC-1:0] active;
    logic [3:0]         next_id;

    // Purpose: a read acknowledges the transmit source only if it saw that code.
    always_comb begin
        rd_ack = iir_rd && (iir[3:0] == ID_THRE);
    end

    uart_irq_thr_flag u_thr_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .ier_wr     (ier_wr),
        .thr_empty  (thr_empty),
        .tx_drained (tx_drained),
        .thr_wr     (thr_wr),
        .rd_ack     (rd_ack),
        .pend       (thr_pend)
    );

    uart_irq_rx_gate #(.FIFO_DEPTH(FIFO_DEPTH)) u_rx_gate (
        .rx_ready (rx_ready),
        .fifo_on  (fifo_on),
        .rx_count (rx_count),
        .trig_sel (trig_sel),
        .rx_avail (rx_avail)
    );

    // Purpose: form each source request with its enable.
    always_comb begin
        active              = '0;
        active[SRC_LINE]    = ier_bits[2] && (|rx_err);
        active[SRC_TIMEOUT] = ier_bits[0] && timeout_pend;
        active[SRC_RXDATA]  = ier_bits[0] && rx_avail;
        active[SRC_THRE]    = ier_bits[1] && thr_pend;
        active[SRC_MODEM]   = ier_bits[3] && (|msr_delta);
    end

    uart_irq_prio #(.N(NUM_SRC)) u_prio (
        .active (active),
        .id     (next_id)
    );

    // Purpose: register the IIR value and the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iir <= {4'h0, ID_NONE};
            irq <= 1'b0;
        end else begin
            iir <= {{2{fifo_on}}, 2'b00, next_id};
            irq <= (next_id != ID_NONE);
        end
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Checker for uart_irq_ident, attached by bind. Relates the registered outputs
// to the inputs sampled one edge earlier, and the pending flag to its strobes.
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier_bits,
    input logic [3:0] rx_err,
    input logic       fifo_on,
    input logic       thr_wr,
    input logic       ier_wr,
    input logic       thr_empty,
    input logic       tx_drained,
    input logic       iir_rd,
    input logic [7:0] iir,
    input logic       irq,
    input logic       thr_pend
);

    p_line_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_bits[2] && (|rx_err)) |=> (iir[3:0] == 4'h6));

    p_none_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_bits == 4'h0) |=> (iir[3:0] == 4'h1 && !irq));

    p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (iir[3:0] != 4'h1));

    p_fifo_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_on |=> (iir[7:6] == 2'b11));

    p_wr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thr_pend);

    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir[3:0] == 4'h2 && !(ier_wr && thr_empty) && !tx_drained)
        |=> !thr_pend);

endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ier_bits   (ier_bits),
    .rx_err     (rx_err),
    .fifo_on    (fifo_on),
    .thr_wr     (thr_wr),
    .ier_wr     (ier_wr),
    .thr_empty  (thr_empty),
    .tx_drained (tx_drained),
    .iir_rd     (iir_rd),
    .iir        (iir),
    .irq        (irq),
    .thr_pend   (thr_pend)
);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    localparam int DEPTH = 16;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ier_bits = '0, rx_err = '0, msr_delta = '0;
    logic rx_ready = 0, fifo_on = 0, timeout_pend = 0, thr_empty = 0;
    logic ier_wr = 0, thr_wr = 0, tx_drained = 0, iir_rd = 0;
    logic [CW-1:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic [7:0] iir;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_pend = 0;
    logic [7:0] exp_iir = 8'h01;

    always #2.5 clk = ~clk;

    uart_irq_ident #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ier_bits(ier_bits), .rx_err(rx_err),
        .rx_ready(rx_ready), .fifo_on(fifo_on), .rx_count(rx_count),
        .trig_sel(trig_sel), .timeout_pend(timeout_pend), .thr_empty(thr_empty),
        .ier_wr(ier_wr), .thr_wr(thr_wr), .tx_drained(tx_drained),
        .iir_rd(iir_rd), .msr_delta(msr_delta), .iir(iir), .irq(irq)
    );

    function automatic int trig_of(input logic [1:0] s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
    endfunction

    // Expected IIR from the requirements for the current inputs.
    function automatic logic [7:0] model_iir(input bit pend);
        logic [3:0] id;
        bit rxa;
        rxa = rx_ready && (!fifo_on || int'(rx_count) >= trig_of(trig_sel));
        if (ier_bits[2] && |rx_err)            id = 4'h6;  // R3
        else if (ier_bits[0] && timeout_pend)  id = 4'hC;  // R4
        else if (ier_bits[0] && rxa)           id = 4'h4;  // R5
        else if (ier_bits[1] && pend)          id = 4'h2;  // R6
        else if (ier_bits[3] && |msr_delta)    id = 4'h0;  // R8
        else                                   id = 4'h1;  // R2
        return {{2{fifo_on}}, 2'b00, id};                  // R9
    endfunction

    function automatic bit model_pend(input bit p, input logic [7:0] shown);
        if (thr_wr) return 0;
        if ((ier_wr && thr_empty) || tx_drained) return 1;
        if (iir_rd && shown[3:0] == 4'h2) return 0;   // R7
        return p;
    endfunction

    task automatic check(input string req);
        checks++;
        if (iir !== exp_iir || irq !== (exp_iir[3:0] != 4'h1)) begin
            errors++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     req, iir, irq, exp_iir, exp_iir[3:0] != 4'h1);
        end
    endtask

    // One cycle: inputs already set at negedge; predict, clock, check.
    task automatic step(input string req);
        logic [7:0] nx;
        bit np;
        nx = model_iir(m_pend);
        np = model_pend(m_pend, exp_iir);
        @(posedge clk);
        exp_iir = nx;
        m_pend = np;
        @(negedge clk);
        ier_wr = 0; thr_wr = 0; tx_drained = 0; iir_rd = 0;
        check(req);
    endtask

    task automatic clear_inputs();
        ier_bits = 0; rx_err = 0; msr_delta = 0; rx_ready = 0; fifo_on = 0;
        timeout_pend = 0; thr_empty = 0; rx_count = 0; trig_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        exp_iir = 8'h01;
        check("R1 reset");
        rst_n = 1;
        // R2: all sources active, line status wins; then peel each off.
        ier_bits = 4'hF; rx_err = 4'h2; timeout_pend = 1; rx_ready = 1;
        msr_delta = 4'h8; thr_empty = 1; ier_wr = 1;
        step("R2 line status top");
        step("R2 R3 line status with pending thr");
        rx_err = 0;  step("R2 R4 timeout next");
        timeout_pend = 0; step("R2 R5 rx data next");
        rx_ready = 0; step("R2 R6 thr next");
        thr_wr = 1; step("R6 thr write clears");
        step("R8 modem last");
        // R4: timeout masked by ier bit 0.
        ier_bits = 4'h4; timeout_pend = 1; msr_delta = 0; step("R4 timeout gated");
        // R5: FIFO trigger boundary at 14.
        clear_inputs(); ier_bits = 4'h1; fifo_on = 1; trig_sel = 2'b11;
        rx_ready = 1; rx_count = 13; step("R5 R9 below trigger");
        rx_count = 14; step("R5 at trigger");
        trig_sel = 2'b01; rx_count = 3; step("R5 below 4");
        rx_count = 4; step("R5 at 4");
        fifo_on = 0; rx_count = 0; step("R5 R9 byte mode");
        // R6/R7: set, read clears, set wins over read.
        clear_inputs(); ier_bits = 4'h2; tx_drained = 1; step("R6 drain sets");
        step("R6 thr shown");
        iir_rd = 1; step("R7 read acks");
        step("R7 cleared");
        tx_drained = 1; step("R6 set again");
        step("R6 shown");
        iir_rd = 1; tx_drained = 1; step("R7 set wins");
        step("R7 still pending");
        thr_wr = 1; tx_drained = 1; step("R6 write wins");
        step("R6 cleared");
        ier_wr = 1; thr_empty = 0; step("R6 no arm when busy");
        step("R6 still none");
        // Random mix.
        void'($urandom(32'h5EED));
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom;
            ier_bits = r[3:0] & $urandom;
            rx_err = (r[4] && r[5]) ? r[9:6] : 4'h0;
            rx_ready = r[10]; fifo_on = r[11];
            rx_count = CW'(r[16:12] % (DEPTH + 1));
            trig_sel = r[18:17];
            timeout_pend = r[19] && r[20];
            thr_empty = r[21];
            ier_wr = r[22]; thr_wr = r[23] && r[24] && r[25];
            tx_drained = r[26] && r[27]; iir_rd = r[28];
            msr_delta = r[29] ? 4'h0 : {r[31:30], r[1:0]};
            step("R2 R10 random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule